// File: doc/BRIEF.md
# PC Card Bus Cycle Timing Sequencer

This block times a single memory or I/O access on a PC Card style parallel bus. All timing is counted in system clock cycles. A 32-bit configuration word sets how long each phase of the access lasts. The word is loaded through a plain full-word write port and can always be read back.

A start request with a direction flag, an address and write data begins an access. The block first drives the address without a command (setup). It then pulls the active-low command strobe for the programmed wait time. Every cycle that the external active-low wait input is low during the command phase adds one cycle to that phase. After the command the address, and the data on a write, stay valid for the hold time. A write then ends with a phase in which address and data are released while the block is still busy. A read takes the bus data on the last command cycle and skips that phase.

Each phase is encoded differently. Setup and command add one cycle to the field value. Hold counts the field value exactly, with 0 promoted to 1. The release phase counts exactly and may be zero. The fields are captured when an access is accepted. A configuration write made during an access therefore changes only the next access.

Top module: `pcc_cycle_seq`

## Requirements
- R1: After reset, cfg_rdata reads 0xFCFCFCFC, and busy, addr_oe, data_oe and done are low while cmd_n is high.
- R2: A cycle with cfg_we high replaces the whole configuration word with cfg_wdata. The fields are: setup time in bits 7:0, wait time in bits 15:8, hold time in bits 23:16, release time in bits 31:24.
- R3: The setup phase lasts setup+1 cycles, with addr_oe high and cmd_n high. It begins in the cycle after start is accepted.
- R4: The command phase (cmd_n low, addr_oe high) lasts wait+1 cycles, plus one cycle for each command cycle that ends with wait_n low. A wait field of 0 acts as 1.
- R5: wait_n has no effect on the length of the setup, hold or release phases.
- R6: The hold phase (addr_oe high, cmd_n high, after the command) lasts hold cycles, with a hold field of 0 acting as 1. bus_addr keeps the accepted address for the whole access.
- R7: After the hold phase of a write, busy stays high with addr_oe and data_oe low for release cycles. A release field of 0 skips the phase.
- R8: On a read, rd_data takes the value of bus_rdata from the last command cycle, and no release phase follows.
- R9: start is accepted only while busy is low. done is high for exactly one cycle: the first idle cycle after the final phase.
- R10: Timing fields are captured when start is accepted. A configuration write during an access does not change that access.
- R11: data_oe is high, with bus_wdata equal to the accepted write data, exactly during the command and hold phases of a write. It stays low throughout a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Full-word configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Current configuration word |
| start | input | 1 | Access request, taken only when idle |
| is_write | input | 1 | Access direction, 1 for write |
| addr_in | input | AW | Access address |
| wdata_in | input | DW | Write data |
| wait_n | input | 1 | Active-low command stretch request |
| bus_rdata | input | DW | Data returned by the bus on reads |
| busy | output | 1 | Access in progress |
| addr_oe | output | 1 | Address valid on bus_addr |
| bus_addr | output | AW | Address of the access |
| cmd_n | output | 1 | Active-low command strobe |
| data_oe | output | 1 | Write data valid on bus_wdata |
| bus_wdata | output | DW | Write data of the access |
| rd_data | output | DW | Data captured by the last read |
| done | output | 1 | One-cycle end-of-access pulse |

## Verification
The properties assume that start is raised only after the two-cycle reset release has finished. They also assume that wait_n, start and the configuration inputs change only between clock edges. The bench drives every input on the falling edge and waits several cycles after reset before its first request. It lowers wait_n on purpose in the setup, hold and release phases to show that the stretch applies only to the command phase. It also re-raises start and rewrites the configuration in the middle of an access, which the properties on done and busy must tolerate.

// File: rtl/pcc_seq_pkg.sv
package pcc_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_CMD   = 3'd2,
    PH_HOLD  = 3'd3,
    PH_HIZ   = 3'd4
  } phase_e;

  localparam int NUM_FIELDS = 4;
  localparam int IDX_SETUP  = 0;
  localparam int IDX_WAIT   = 1;
  localparam int IDX_HOLD   = 2;
  localparam int IDX_HIZ    = 3;
endpackage

// File: rtl/pcc_rst_sync.sv
module pcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pcc_cfg_reg.sv
module pcc_cfg_reg
  import pcc_seq_pkg::*;
#(
  parameter int          FW        = 8,
  parameter logic [FW-1:0] FIELD_RST = 8'hFC,
  localparam int         CW        = NUM_FIELDS * FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] q
);
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    logic [FW-1:0] fld_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  fld_q <= FIELD_RST;
      else if (we) fld_q <= wdata[g*FW +: FW];
    end
    assign q[g*FW +: FW] = fld_q;
  end
endmodule

// File: rtl/pcc_phase_timer.sv
module pcc_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = load | dec;
    if (load)                   cnt_d = load_val;
    else if (dec && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pcc_seq_fsm.sv
module pcc_seq_fsm
  import pcc_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int FW = 8,
  localparam int CW = NUM_FIELDS * FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg,
  input  logic          start,
  input  logic          is_write,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic          wait_n,
  input  logic [DW-1:0] bus_rdata,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [FW-1:0] tmr_val,
  output logic          tmr_dec,
  output logic          busy,
  output logic          addr_oe,
  output logic [AW-1:0] bus_addr,
  output logic          cmd_n,
  output logic          data_oe,
  output logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] rd_data,
  output logic          done
);
  phase_e        state_q, state_d;
  logic          wr_q;
  logic [FW-1:0] wt_q, hld_q, hiz_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q, rd_q;
  logic          done_q, done_d;
  logic          accept, capture;
  logic [FW-1:0] wt_eff, hld_last;

  // reserved zero in wait/hold is promoted to one cycle
  assign wt_eff   = (wt_q == '0)  ? FW'(1) : wt_q;
  assign hld_last = (hld_q == '0) ? '0     : hld_q - 1'b1;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_dec  = 1'b0;
    done_d   = 1'b0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (start) begin
          accept   = 1'b1;
          state_d  = PH_SETUP;
          tmr_load = 1'b1;
          tmr_val  = cfg[IDX_SETUP*FW +: FW];
        end
      end
      PH_SETUP: begin
        if (tmr_zero) begin
          state_d  = PH_CMD;
          tmr_load = 1'b1;
          tmr_val  = wt_eff;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      PH_CMD: begin
        if (wait_n) begin
          if (tmr_zero) begin
            state_d  = PH_HOLD;
            tmr_load = 1'b1;
            tmr_val  = hld_last;
            capture  = ~wr_q;
          end else begin
            tmr_dec = 1'b1;
          end
        end
      end
      PH_HOLD: begin
        if (tmr_zero) begin
          if (wr_q && hiz_q != '0) begin
            state_d  = PH_HIZ;
            tmr_load = 1'b1;
            tmr_val  = hiz_q - 1'b1;
          end else begin
            state_d = PH_IDLE;
            done_d  = 1'b1;
          end
        end else begin
          tmr_dec = 1'b1;
        end
      end
      PH_HIZ: begin
        if (tmr_zero) begin
          state_d = PH_IDLE;
          done_d  = 1'b1;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      wt_q   <= '0;
      hld_q  <= '0;
      hiz_q  <= '0;
      addr_q <= '0;
      wdat_q <= '0;
    end else if (accept) begin
      wr_q   <= is_write;
      wt_q   <= cfg[IDX_WAIT*FW +: FW];
      hld_q  <= cfg[IDX_HOLD*FW +: FW];
      hiz_q  <= cfg[IDX_HIZ*FW +: FW];
      addr_q <= addr_in;
      wdat_q <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (capture) rd_q <= bus_rdata;
  end

  assign busy      = (state_q != PH_IDLE);
  assign addr_oe   = (state_q == PH_SETUP) || (state_q == PH_CMD) || (state_q == PH_HOLD);
  assign cmd_n     = (state_q != PH_CMD);
  assign data_oe   = wr_q && ((state_q == PH_CMD) || (state_q == PH_HOLD));
  assign bus_addr  = addr_q;
  assign bus_wdata = wdat_q;
  assign rd_data   = rd_q;
  assign done      = done_q;
endmodule

// File: rtl/pcc_cycle_seq.sv
module pcc_cycle_seq
  import pcc_seq_pkg::*;
#(
  parameter int            AW        = 16,
  parameter int            DW        = 16,
  parameter int            FW        = 8,
  parameter logic [FW-1:0] FIELD_RST = 8'hFC,
  localparam int           CW        = NUM_FIELDS * FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_wdata,
  output logic [CW-1:0] cfg_rdata,
  input  logic          start,
  input  logic          is_write,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic          wait_n,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          addr_oe,
  output logic [AW-1:0] bus_addr,
  output logic          cmd_n,
  output logic          data_oe,
  output logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] rd_data,
  output logic          done
);
  logic          rst_n_s;
  logic          tmr_load, tmr_dec, tmr_zero;
  logic [FW-1:0] tmr_val;

  pcc_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  pcc_cfg_reg #(.FW(FW), .FIELD_RST(FIELD_RST)) cfg_i (
    .clk(clk), .rst_n(rst_n_s), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_rdata)
  );

  pcc_phase_timer #(.W(FW)) tmr_i (
    .clk(clk), .rst_n(rst_n_s), .load(tmr_load), .load_val(tmr_val),
    .dec(tmr_dec), .zero(tmr_zero)
  );

  pcc_seq_fsm #(.AW(AW), .DW(DW), .FW(FW)) fsm_i (
    .clk(clk), .rst_n(rst_n_s), .cfg(cfg_rdata), .start(start),
    .is_write(is_write), .addr_in(addr_in), .wdata_in(wdata_in),
    .wait_n(wait_n), .bus_rdata(bus_rdata), .tmr_zero(tmr_zero),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_dec(tmr_dec),
    .busy(busy), .addr_oe(addr_oe), .bus_addr(bus_addr), .cmd_n(cmd_n),
    .data_oe(data_oe), .bus_wdata(bus_wdata), .rd_data(rd_data), .done(done)
  );
endmodule

// File: rtl/pcc_cycle_seq_chk.sv
module pcc_cycle_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          wait_n,
  input logic          busy,
  input logic          addr_oe,
  input logic [AW-1:0] bus_addr,
  input logic          cmd_n,
  input logic          data_oe,
  input logic          done
);
  // R3: the command strobe is only ever raised with a valid address
  p_cmd_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_n |-> addr_oe);

  // R4: a low wait input keeps the command phase open
  p_wait_stretch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_n && !wait_n) |=> !cmd_n);

  // R6: the address does not move while it is driven
  p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe |=> (!addr_oe || $stable(bus_addr)));

  // R11: write data is only driven alongside the address
  p_data_in_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> addr_oe);

  // R9: done is a single-cycle pulse
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: done appears in an idle cycle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: a request while idle starts an access
  p_start_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

bind pcc_cycle_seq pcc_cycle_seq_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .wait_n(wait_n), .busy(busy),
  .addr_oe(addr_oe), .bus_addr(bus_addr), .cmd_n(cmd_n), .data_oe(data_oe),
  .done(done)
);

// File: tb/pcc_cycle_seq_tb_top.sv
module pcc_cycle_seq_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 16;
  localparam int DW = 16;

  typedef struct {
    int          s_len, c_len, h_len, z_len;
    bit          wr;
    logic [AW-1:0] a;
    logic [DW-1:0] w, r;
  } exp_t;

  logic          clk, rst_n, cfg_we, start, is_write, wait_n;
  logic [31:0]   cfg_wdata, cfg_rdata;
  logic [AW-1:0] addr_in, bus_addr;
  logic [DW-1:0] wdata_in, bus_rdata, bus_wdata, rd_data;
  logic          busy, addr_oe, cmd_n, data_oe, done;

  int   n_chk = 0;
  int   n_err = 0;
  exp_t exp_q[$];
  bit   mon_en = 0;

  pcc_cycle_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .start(start), .is_write(is_write),
    .addr_in(addr_in), .wdata_in(wdata_in), .wait_n(wait_n),
    .bus_rdata(bus_rdata), .busy(busy), .addr_oe(addr_oe),
    .bus_addr(bus_addr), .cmd_n(cmd_n), .data_oe(data_oe),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: measures phase lengths at the ports and compares at done
  int cs = 0, cc = 0, ch = 0, cz = 0;
  bit seen_cmd = 0, done_prev = 0;
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (done_prev) chk(!done, "R9 done width", done, 0);
      if (busy) begin
        if (exp_q.size() == 0) chk(0, "R9 busy without request", 1, 0);
        else begin
          if (addr_oe) chk(bus_addr == exp_q[0].a, "R6 address", bus_addr, exp_q[0].a);
          if (addr_oe && cmd_n && !seen_cmd) begin
            cs++;
            chk(!data_oe, "R11 no data in setup", data_oe, 0);
          end else if (!cmd_n) begin
            cc++; seen_cmd = 1;
            chk(data_oe == exp_q[0].wr, "R11 data_oe in command", data_oe, exp_q[0].wr);
            if (exp_q[0].wr) chk(bus_wdata == exp_q[0].w, "R11 write data", bus_wdata, exp_q[0].w);
          end else if (addr_oe) begin
            ch++;
            chk(data_oe == exp_q[0].wr, "R6 data held in hold", data_oe, exp_q[0].wr);
            if (exp_q[0].wr) chk(bus_wdata == exp_q[0].w, "R6 write data held", bus_wdata, exp_q[0].w);
          end else begin
            cz++;
            chk(!data_oe, "R7 data released", data_oe, 0);
          end
        end
      end
      if (done) begin
        chk(!busy, "R9 done in idle cycle", busy, 0);
        if (exp_q.size() == 0) chk(0, "R9 done without request", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(cs == e.s_len, "R3 setup length", cs, e.s_len);
          chk(cc == e.c_len, "R4 command length", cc, e.c_len);
          chk(ch == e.h_len, "R6 hold length", ch, e.h_len);
          chk(cz == e.z_len, "R7 release length", cz, e.z_len);
          if (!e.wr) chk(rd_data == e.r, "R8 read data", rd_data, e.r);
        end
        cs = 0; cc = 0; ch = 0; cz = 0; seen_cmd = 0;
      end
      done_prev = done;
    end
  end

  // driver: one access; pushes the expected item, then steers wait_n and bus_rdata
  task automatic access(input bit use_cfg, input logic [7:0] st, input logic [7:0] wt,
                        input logic [7:0] hl, input logic [7:0] hz, input bit wr,
                        input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic [DW-1:0] rv, input int nw, input bit noise,
                        input bit bad_start, input bit cfg_mid);
    exp_t e;
    int   wte, cmd_c, cmd_tot;
    bit   mid_done;
    logic [31:0] alt;
    if (use_cfg) begin
      cfg_we = 1'b1; cfg_wdata = {hz, hl, wt, st};
      @(negedge clk);
      cfg_we = 1'b0;
      chk(cfg_rdata == {hz, hl, wt, st}, "R2 config write", cfg_rdata, {hz, hl, wt, st});
    end else begin
      {hz, hl, wt, st} = cfg_rdata;
    end
    wte       = (wt == 0) ? 1 : int'(wt);
    cmd_tot   = wte + 1 + nw;
    e.s_len   = int'(st) + 1;
    e.c_len   = cmd_tot;
    e.h_len   = (hl == 0) ? 1 : int'(hl);
    e.z_len   = wr ? int'(hz) : 0;
    e.wr      = wr;
    e.a       = a;
    e.w       = wd;
    e.r       = rv;
    exp_q.push_back(e);
    start = 1'b1; is_write = wr; addr_in = a; wdata_in = wd;
    @(negedge clk);
    start = 1'b0;
    cmd_c = 0; mid_done = 0;
    alt = ~{hz, hl, wt, st};
    while (!done) begin
      cfg_we = 1'b0;
      if (!cmd_n) begin
        cmd_c++;
        wait_n    = (cmd_c <= nw) ? 1'b0 : 1'b1;
        bus_rdata = (cmd_c == cmd_tot) ? rv : ~rv;
        if (cfg_mid && !mid_done) begin
          cfg_we = 1'b1; cfg_wdata = alt; mid_done = 1;
        end
      end else begin
        wait_n    = noise ? 1'b0 : 1'b1;   // R5: ignored outside command phase
        bus_rdata = ~rv;
      end
      start   = bad_start && busy;         // R9: request while busy
      addr_in = ~a;
      @(negedge clk);
    end
    start = 1'b0; wait_n = 1'b1; cfg_we = 1'b0;
    if (cfg_mid) chk(cfg_rdata == alt, "R10 write during access kept for next", cfg_rdata, alt);
    @(negedge clk);
    chk(!busy, "R9 no restart after done", busy, 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; start = 1'b0; is_write = 1'b0;
    addr_in = '0; wdata_in = '0; wait_n = 1'b1; bus_rdata = '0;
    repeat (3) @(negedge clk);
    chk(cfg_rdata == 32'hFCFCFCFC, "R1 reset config", cfg_rdata, 32'hFCFCFCFC);
    chk(!busy && !addr_oe && !data_oe && !done, "R1 reset outputs low",
        {busy, addr_oe, data_oe, done}, 0);
    chk(cmd_n, "R1 reset strobe high", cmd_n, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1;
    // R1: reset timing used as is (write)
    access(0, 0, 0, 0, 0, 1, 16'h1234, 16'hBEEF, 16'h0, 0, 0, 0, 0);
    // minimum fields, reserved zeros promoted (R4, R6, R7)
    access(1, 8'h00, 8'h00, 8'h00, 8'h00, 1, 16'h0001, 16'hA5A5, 16'h0, 0, 0, 0, 0);
    // read with stretch and noise (R4, R5, R8)
    access(1, 8'h03, 8'h02, 8'h02, 8'h05, 0, 16'h00F0, 16'h0, 16'h5A3C, 3, 1, 0, 0);
    // write with stretch, noise, restart attempt, mid-access config write (R9, R10)
    access(1, 8'h02, 8'h01, 8'h03, 8'h04, 1, 16'hCAFE, 16'h7E57, 16'h0, 2, 1, 1, 1);
    // read, minimum timing (R8)
    access(1, 8'h00, 8'h00, 8'h01, 8'h09, 0, 16'h0ACE, 16'h0, 16'h9001, 0, 0, 1, 0);
    // write, zero release with noise (R7)
    access(1, 8'h01, 8'h03, 8'h02, 8'h00, 1, 16'h7777, 16'h3141, 16'h0, 1, 1, 0, 0);
    // maximum setup and release (R3, R7)
    access(1, 8'hFF, 8'h05, 8'h01, 8'hFF, 1, 16'hFFFF, 16'h0F0F, 16'h0, 4, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 every access completed", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule